// File: doc/BRIEF.md
# Gated Capacitively-Coupled Set/Reset Trigger

This block models a storage trigger from discrete-transistor logic. It has two AC inputs, one to set and one to clear, and each is coupled through a capacitor. Each AC input has its own gate enable. An AC input changes the stored state only when it makes a fresh 0-to-1 transition while its gate is enabled. A level that is already high when the gate opens does nothing. This stops a chain of timing triggers from stepping ahead on a pulse that was already present when the chain became ready.

The whole block runs on one fast system clock. Edges are found by comparing each AC input with its value one clock earlier. Two DC force inputs, one to set and one to clear, act in the same clocked process and override the AC path. The block drives a registered true output and a registered complementary output.

Top module: `gated_edge_trigger`

## Requirements
- R1: When `rst` is sampled high at a clock edge, `q` takes the value of INIT_STATE (default 0) and `q_n` takes its inverse. Both edge memories are loaded with 1. As a result, an AC input that is high through the release of reset causes no change.
- R2: A 0-to-1 change of `ac_set` between two consecutive clock edges makes `q` 1 one clock later, provided `ac_set_gate` is high at the second edge and no force is active.
- R3: A rising `ac_set` or `ac_clr` whose gate is low at the edge where the new level is sampled leaves `q` unchanged.
- R4: An AC input that was already high when its gate went high leaves `q` unchanged. A later 0-then-1 change, made while the gate stays high, does act.
- R5: `ac_clr`, qualified by `ac_clr_gate`, follows the same transition rule as the set input and makes `q` 0.
- R6: A qualified set edge and a qualified clear edge sampled at the same clock edge invert `q`.
- R7: `force_set` alone makes `q` 1 at the next clock and `force_clr` alone makes `q` 0, whatever the AC inputs do in that cycle.
- R8: `force_set` and `force_clr` high together hold `q`. Any AC edge in that cycle is dropped.
- R9: Outside reset, `q_n` is always the exact inverse of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ac_set | input | 1 | Capacitively coupled set input |
| ac_set_gate | input | 1 | Enable for the set input |
| ac_clr | input | 1 | Capacitively coupled clear input |
| ac_clr_gate | input | 1 | Enable for the clear input |
| force_set | input | 1 | DC force to 1, overrides AC path |
| force_clr | input | 1 | DC force to 0, overrides AC path |
| q | output | 1 | Registered trigger state |
| q_n | output | 1 | Registered complement of q |

## Verification
The assertions check on every cycle the rules that need no input history: the state after reset, the complement relation, the force outcomes, and hold while both gates are closed. Rules that depend on the previous level of an AC input can only be shown by the bench's scenarios. These are a level already high at gate opening, a level high across reset release, a fresh edge under an open gate, and the toggle on simultaneous edges. The bench drives those sequences and compares the outputs with its own model.

// File: rtl/gtrig_pkg.sv
package gtrig_pkg;

    localparam int unsigned AC_CH  = 2;
    localparam int unsigned CH_SET = 0;
    localparam int unsigned CH_CLR = 1;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_SET    = 2'd1,
        ACT_CLR    = 2'd2,
        ACT_TOGGLE = 2'd3
    } trig_act_e;

    typedef struct packed {
        logic force_set;
        logic force_clr;
        logic fire_set;
        logic fire_clr;
    } trig_req_t;

    // DC forces dominate; a conflicting force pair holds; AC pair toggles.
    function automatic trig_act_e resolve_act(input trig_req_t r);
        trig_act_e a;
        if (r.force_set && r.force_clr)      a = ACT_HOLD;
        else if (r.force_set)                a = ACT_SET;
        else if (r.force_clr)                a = ACT_CLR;
        else if (r.fire_set && r.fire_clr)   a = ACT_TOGGLE;
        else if (r.fire_set)                 a = ACT_SET;
        else if (r.fire_clr)                 a = ACT_CLR;
        else                                 a = ACT_HOLD;
        return a;
    endfunction

    function automatic logic apply_act(input trig_act_e a, input logic cur);
        logic nxt;
        case (a)
            ACT_SET:    nxt = 1'b1;
            ACT_CLR:    nxt = 1'b0;
            ACT_TOGGLE: nxt = ~cur;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/gtrig_edge_qual.sv
module gtrig_edge_qual #(
    parameter bit MEM_INIT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic gate,
    output logic fire
);

    logic lvl_d;

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= MEM_INIT;
        else     lvl_d <= lvl;
    end

    // Only a fresh rising transition seen under an open gate counts.
    always_comb fire = gate & lvl & ~lvl_d;

endmodule

// File: rtl/gtrig_core.sv
module gtrig_core
    import gtrig_pkg::*;
#(
    parameter bit INIT_STATE = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  trig_req_t req,
    output logic      q,
    output logic      q_n
);

    trig_act_e act;
    logic      q_nxt;

    always_comb begin
        act   = resolve_act(req);
        q_nxt = apply_act(act, q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= INIT_STATE;
            q_n <= ~INIT_STATE;
        end else begin
            q   <= q_nxt;
            q_n <= ~q_nxt;
        end
    end

endmodule

// File: rtl/gated_edge_trigger.sv
module gated_edge_trigger
    import gtrig_pkg::*;
#(
    parameter bit INIT_STATE    = 1'b0,
    parameter bit EDGE_MEM_INIT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ac_set,
    input  logic ac_set_gate,
    input  logic ac_clr,
    input  logic ac_clr_gate,
    input  logic force_set,
    input  logic force_clr,
    output logic q,
    output logic q_n
);

    logic [AC_CH-1:0] ch_lvl;
    logic [AC_CH-1:0] ch_gate;
    logic [AC_CH-1:0] ch_fire;
    trig_req_t        req;

    always_comb begin
        ch_lvl[CH_SET]  = ac_set;
        ch_lvl[CH_CLR]  = ac_clr;
        ch_gate[CH_SET] = ac_set_gate;
        ch_gate[CH_CLR] = ac_clr_gate;
    end

    for (genvar c = 0; c < AC_CH; c++) begin : g_ch
        gtrig_edge_qual #(
            .MEM_INIT (EDGE_MEM_INIT)
        ) u_qual (
            .clk  (clk),
            .rst  (rst),
            .lvl  (ch_lvl[c]),
            .gate (ch_gate[c]),
            .fire (ch_fire[c])
        );
    end

    always_comb begin
        req.force_set = force_set;
        req.force_clr = force_clr;
        req.fire_set  = ch_fire[CH_SET];
        req.fire_clr  = ch_fire[CH_CLR];
    end

    gtrig_core #(
        .INIT_STATE (INIT_STATE)
    ) u_core (
        .clk (clk),
        .rst (rst),
        .req (req),
        .q   (q),
        .q_n (q_n)
    );

endmodule

// File: rtl/gtrig_chk.sv
module gtrig_chk #(
    parameter bit INIT_STATE = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic ac_set_gate,
    input logic ac_clr_gate,
    input logic force_set,
    input logic force_clr,
    input logic q,
    input logic q_n
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (q == INIT_STATE && q_n == !INIT_STATE));

    // R9
    compl_out_chk: assert property (@(posedge clk) disable iff (rst)
        q_n == !q);

    // R7
    force_set_win_chk: assert property (@(posedge clk) disable iff (rst)
        (force_set && !force_clr) |=> q);

    // R7
    force_clr_win_chk: assert property (@(posedge clk) disable iff (rst)
        (force_clr && !force_set) |=> !q);

    // R8
    force_pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (force_set && force_clr) |=> $stable(q));

    // R3
    gates_closed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!force_set && !force_clr && !ac_set_gate && !ac_clr_gate) |=> $stable(q));

endmodule

bind gated_edge_trigger gtrig_chk #(
    .INIT_STATE (INIT_STATE)
) u_gtrig_chk (
    .clk         (clk),
    .rst         (rst),
    .ac_set_gate (ac_set_gate),
    .ac_clr_gate (ac_clr_gate),
    .force_set   (force_set),
    .force_clr   (force_clr),
    .q           (q),
    .q_n         (q_n)
);

// File: tb/gated_edge_trigger_tb.sv
module gated_edge_trigger_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_STEPS = 600;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ac_set = 1'b0, ac_set_gate = 1'b0;
    logic ac_clr = 1'b0, ac_clr_gate = 1'b0;
    logic force_set = 1'b0, force_clr = 1'b0;
    logic q, q_n;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // bench model state
    logic m_q = 1'b0;
    logic m_set_prev = 1'b1;
    logic m_clr_prev = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_edge_trigger dut_i (
        .clk (clk), .rst (rst),
        .ac_set (ac_set), .ac_set_gate (ac_set_gate),
        .ac_clr (ac_clr), .ac_clr_gate (ac_clr_gate),
        .force_set (force_set), .force_clr (force_clr),
        .q (q), .q_n (q_n)
    );

    function automatic logic model_next(input logic cur, input logic s_ev, input logic c_ev,
                                        input logic fs, input logic fc);
        if (fs && fc)       return cur;
        if (fs)             return 1'b1;
        if (fc)             return 1'b0;
        if (s_ev && c_ev)   return ~cur;
        if (s_ev)           return 1'b1;
        if (c_ev)           return 1'b0;
        return cur;
    endfunction

    function automatic string classify(input logic s_ev, input logic c_ev,
                                       input logic fs, input logic fc);
        if (fs && fc)     return "R8";
        if (fs || fc)     return "R7";
        if (s_ev && c_ev) return "R6";
        if (s_ev)         return "R2";
        if (c_ev)         return "R5";
        if ((ac_set && ac_set_gate) || (ac_clr && ac_clr_gate)) return "R4";
        return "R3";
    endfunction

    task automatic check(input string req, input logic exp);
        vectors++;
        if (q !== exp || q_n !== ~exp) begin
            miscompares++;
            $display("FAIL %s: q=%b q_n=%b expected q=%b q_n=%b", req, q, q_n, exp, ~exp);
        end
    endtask

    // Drive at negedge, clock once, check at the following negedge.
    task automatic step(input logic s, input logic sg, input logic c, input logic cg,
                        input logic fs, input logic fc, input string tag_in);
        logic s_ev, c_ev;
        string tag;
        ac_set = s; ac_set_gate = sg; ac_clr = c; ac_clr_gate = cg;
        force_set = fs; force_clr = fc;
        s_ev = sg && s && !m_set_prev;
        c_ev = cg && c && !m_clr_prev;
        tag  = (tag_in == "") ? classify(s_ev, c_ev, fs, fc) : tag_in;
        m_q  = model_next(m_q, s_ev, c_ev, fs, fc);
        m_set_prev = s;
        m_clr_prev = c;
        @(posedge clk);
        @(negedge clk);
        check(tag, m_q);
    endtask

    task automatic do_reset(input logic s_hold, input logic c_hold);
        rst = 1'b1;
        ac_set = s_hold; ac_set_gate = 1'b1; ac_clr = c_hold; ac_clr_gate = 1'b1;
        force_set = 1'b0; force_clr = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_q = 1'b0; m_set_prev = 1'b1; m_clr_prev = 1'b1;
        check("R1", 1'b0);
    endtask

    initial begin
        void'($urandom(32'd1410));
        @(negedge clk);
        // R1: inputs high with gates open across reset release: no fire
        do_reset(1'b1, 1'b0);
        step(1, 1, 0, 1, 0, 0, "R1");
        step(1, 1, 0, 1, 0, 0, "R1");
        // R3: rising set with gate closed
        step(0, 0, 0, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 0, 0, "R3");
        // R4: level already high, gate opens -> no change; fresh edge -> set
        step(1, 1, 0, 0, 0, 0, "R4");
        step(1, 1, 0, 0, 0, 0, "R4");
        step(0, 1, 0, 0, 0, 0, "R4");
        step(1, 1, 0, 0, 0, 0, "R4");
        // R5: clear edge under open gate
        step(0, 0, 1, 1, 0, 0, "R5");
        // R2: set edge
        step(1, 1, 0, 0, 0, 0, "R2");
        // R6: both edges together toggle, twice
        step(0, 0, 0, 0, 0, 0, "R6");
        step(1, 1, 1, 1, 0, 0, "R6");
        step(0, 1, 0, 1, 0, 0, "R6");
        step(1, 1, 1, 1, 0, 0, "R6");
        // R7: force clear against set edge, force set against clear edge
        step(0, 1, 0, 1, 0, 0, "R7");
        step(1, 1, 0, 1, 0, 1, "R7");
        step(0, 1, 1, 1, 1, 0, "R7");
        // R8: both forces with a clear edge pending -> hold
        step(0, 1, 0, 1, 0, 0, "R8");
        step(0, 1, 1, 1, 1, 1, "R8");
        // R9 checked on every vector through q_n comparison
        // random phase
        for (int i = 0; i < RAND_STEPS; i++) begin
            logic fs, fc;
            fs = ($urandom % 8) == 0;
            fc = ($urandom % 8) == 0;
            step($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, fs, fc, "");
            if (i == RAND_STEPS/2) do_reset(1'b1, 1'b1);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL all: watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule